// File: doc/BRIEF.md
# Handshaked Two-Wire Bit Transmitter

This block sends a stream of bytes to one far-end device over two shared open-drain wires, here called line A and line B. No clock travels with the data. Every bit completes a full four-phase exchange: the transmitter pulls one wire low, waits until the far end acknowledges on the other wire, lets its own wire go, and waits until the acknowledgement is withdrawn. The bit value is chosen by which wire the transmitter pulls, so either side may stall for any length of time without losing or corrupting a bit.

Bytes arrive on a valid/ready interface with a last flag and a reply-expected flag. The block frames each message itself. A message starts with one 1 bit. Each byte is sent as a 0 start bit followed by the data bits. A 1 bit in the place of the next start bit closes the message. When the closing byte asks for a reply, the block watches for the far end to keep line B low after the final exchange. It then reports with a single-cycle pulse that the link now belongs to the far end, and lets both wires go.

The block drives two active-low pull-down enables and reads back the resolved level of each wire. Both read-back levels pass through clock-domain synchronizers before any decision is taken on them.

Top module: `hs2w_tx`

## Requirements
- R1: While reset is asserted and on leaving it, both pull-down enables are high (both wires released), in_ready is high and released_o is low.
- R2: A 0 bit pulls line A (pd_a_n low) and keeps it pulled until line B is seen low. A is then released, and no further bit starts until line B is seen high again.
- R3: A 1 bit pulls line B (pd_b_n low) and keeps it pulled until line A is seen low. B is then released, and no further bit starts until line A is seen high again.
- R4: Each byte is sent as a 0 start bit, then DATA_W data bits, least significant bit first.
- R5: The first byte of a message is preceded by exactly one 1 bit. Later bytes of the same message have no such bit.
- R6: After the data bits of a byte flagged last, exactly one 1 bit is sent in the slot of the next start bit.
- R7: A byte is taken at a rising edge where in_valid and in_ready are both high. in_ready is high only between bytes and between messages, and is low at every cycle in which a wire is pulled.
- R8: Each resolved line level passes through SYNC_STAGES flops before it is used. A change driven by the far end alters a pull-down enable no earlier than SYNC_STAGES+1 rising edges later.
- R9: When the last byte has in_reply set, the block finishes the closing 1 bit. If line B is then seen low, released_o pulses high for one cycle with both enables high. The block then pulls neither wire until a new byte is offered.
- R10: in_reply on a byte not flagged last has no effect: no turnaround takes place and released_o stays low. A message without a reply request never pulses released_o.
- R11: The block never pulls both wires in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_data | input | DATA_W | Byte to send |
| in_valid | input | 1 | in_data holds a byte |
| in_last | input | 1 | Byte closes the message |
| in_reply | input | 1 | Hand the link to the far end after this message (only honoured with in_last) |
| in_ready | output | 1 | Block can take a byte this cycle |
| line_a_i | input | 1 | Resolved level of line A (1 = high) |
| line_b_i | input | 1 | Resolved level of line B (1 = high) |
| pd_a_n | output | 1 | Pull-down enable for line A, active low |
| pd_b_n | output | 1 | Pull-down enable for line B, active low |
| released_o | output | 1 | One-cycle pulse: the far end has taken over the link |

## Verification
The bench builds the block with DATA_W of 8 and SYNC_STAGES of 2. With two synchronizer stages, the three-edge reaction bound of R8 can be measured exactly against the far-end model. Each acknowledgement and withdrawal from that model is delayed by a varying 0 to 7 cycles, so the transmitter meets both immediate and stalled partners. Byte values of all zeros, all ones and mixed patterns exercise both wire roles. Messages with pauses between bytes, with and without a reply, and with the reply flag on a non-final byte reach the turnaround path and show that it is ignored where it must be.

// File: rtl/hs2w_pkg.sv
`timescale 1ns/1ps
package hs2w_pkg;

    // Phase of the single-bit four-phase exchange
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_DRIVE   = 2'd1,
        PH_RELEASE = 2'd2
    } phase_e;

    // Position inside a message
    typedef enum logic [2:0] {
        FR_IDLE  = 3'd0,
        FR_GAP   = 3'd1,
        FR_PRE   = 3'd2,
        FR_START = 3'd3,
        FR_DATA  = 3'd4,
        FR_END   = 3'd5,
        FR_TURN  = 3'd6
    } frame_e;

    typedef struct packed {
        phase_e ph;
        logic   val;
    } eng_t;

endpackage

// File: rtl/hs2w_sync.sv
`timescale 1ns/1ps
module hs2w_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic sync_o
);
    localparam int DEPTH = (STAGES < 1) ? 1 : STAGES;

    logic [DEPTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = raw_i;
        for (int s = 1; s < DEPTH; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    // released wires read high, so the chain resets to 1
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '1;
        else        stg_q <= stg_d;
    end

    assign sync_o = stg_q[DEPTH-1];

endmodule

// File: rtl/hs2w_bitphase.sv
`timescale 1ns/1ps
module hs2w_bitphase
    import hs2w_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    input  logic val_i,
    input  logic a_low_i,
    input  logic b_low_i,
    output logic pull_a_o,
    output logic pull_b_o,
    output logic idle_o,
    output logic done_o
);
    eng_t eng_d, eng_q;
    logic peer_low;

    // the acknowledging wire is the one not pulled for this value
    assign peer_low = eng_q.val ? a_low_i : b_low_i;

    always_comb begin
        eng_d  = eng_q;
        done_o = 1'b0;
        case (eng_q.ph)
            PH_IDLE: begin
                if (go_i) begin
                    eng_d.ph  = PH_DRIVE;
                    eng_d.val = val_i;
                end
            end
            PH_DRIVE: begin
                if (peer_low) eng_d.ph = PH_RELEASE;
            end
            PH_RELEASE: begin
                if (!peer_low) begin
                    eng_d.ph = PH_IDLE;
                    done_o   = 1'b1;
                end
            end
            default: eng_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '{ph: PH_IDLE, val: 1'b0};
        else        eng_q <= eng_d;
    end

    assign pull_a_o = (eng_q.ph == PH_DRIVE) && !eng_q.val;
    assign pull_b_o = (eng_q.ph == PH_DRIVE) &&  eng_q.val;
    assign idle_o   = (eng_q.ph == PH_IDLE);

    // R2: line A stays pulled until B is seen low
    a_r2_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_a_o && !b_low_i) |=> pull_a_o);

    // R3: line B stays pulled until A is seen low
    a_r3_hold_one: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_b_o && !a_low_i) |=> pull_b_o);

    // R2: A is let go only after the acknowledgement on B
    a_r2_ack_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pull_a_o) |-> $past(b_low_i));

    // R3: B is let go only after the acknowledgement on A
    a_r3_ack_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pull_b_o) |-> $past(a_low_i));

endmodule

// File: rtl/hs2w_framer.sv
`timescale 1ns/1ps
module hs2w_framer
    import hs2w_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic              in_reply,
    output logic              in_ready,
    input  logic              eng_idle_i,
    input  logic              eng_done_i,
    input  logic              b_low_i,
    output logic              go_o,
    output logic              val_o,
    output logic              released_o
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(DATA_W - 1);

    typedef struct packed {
        frame_e            st;
        logic [DATA_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              last;
        logic              reply;
        logic              rel;
    } frm_t;

    frm_t frm_d, frm_q;
    logic take;
    logic bit_slot;

    assign in_ready = (frm_q.st == FR_IDLE) || (frm_q.st == FR_GAP);
    assign take     = in_valid && in_ready;
    assign bit_slot = (frm_q.st == FR_PRE) || (frm_q.st == FR_START) ||
                      (frm_q.st == FR_DATA) || (frm_q.st == FR_END);
    assign go_o     = bit_slot && eng_idle_i;

    always_comb begin
        case (frm_q.st)
            FR_START: val_o = 1'b0;
            FR_DATA:  val_o = frm_q.sh[0];
            default:  val_o = 1'b1;
        endcase
    end

    always_comb begin
        frm_d     = frm_q;
        frm_d.rel = 1'b0;
        case (frm_q.st)
            FR_IDLE, FR_GAP: begin
                if (take) begin
                    frm_d.sh    = in_data;
                    frm_d.last  = in_last;
                    frm_d.reply = in_reply;
                    frm_d.cnt   = '0;
                    frm_d.st    = (frm_q.st == FR_IDLE) ? FR_PRE : FR_START;
                end
            end
            FR_PRE: begin
                if (eng_done_i) frm_d.st = FR_START;
            end
            FR_START: begin
                if (eng_done_i) frm_d.st = FR_DATA;
            end
            FR_DATA: begin
                if (eng_done_i) begin
                    frm_d.sh = frm_q.sh >> 1;
                    if (frm_q.cnt == CNT_TOP) begin
                        frm_d.st = frm_q.last ? FR_END : FR_GAP;
                    end else begin
                        frm_d.cnt = frm_q.cnt + 1'b1;
                    end
                end
            end
            FR_END: begin
                if (eng_done_i) frm_d.st = frm_q.reply ? FR_TURN : FR_IDLE;
            end
            FR_TURN: begin
                if (b_low_i) begin
                    frm_d.rel = 1'b1;
                    frm_d.st  = FR_IDLE;
                end
            end
            default: frm_d.st = FR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_q <= '{st: FR_IDLE, sh: '0, cnt: '0, last: 1'b0, reply: 1'b0, rel: 1'b0};
        end else begin
            frm_q <= frm_d;
        end
    end

    assign released_o = frm_q.rel;

    // R7: bytes are taken only while no bit exchange is running
    a_r7_ready_engine_idle: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> eng_idle_i);

    // R7: a taken byte closes the window at once
    a_r7_take_closes: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !in_ready);

    // R9: the hand-over indication lasts one cycle
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        released_o |=> !released_o);

endmodule

// File: rtl/hs2w_tx.sv
`timescale 1ns/1ps
module hs2w_tx #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic              in_reply,
    output logic              in_ready,
    input  logic              line_a_i,
    input  logic              line_b_i,
    output logic              pd_a_n,
    output logic              pd_b_n,
    output logic              released_o
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw_lvl;
    logic [LINES-1:0] sync_lvl;
    logic a_low, b_low;
    logic pull_a, pull_b;
    logic eng_idle, eng_done;
    logic bit_go, bit_val;

    assign raw_lvl = {line_b_i, line_a_i};

    for (genvar i = 0; i < LINES; i++) begin : g_sync
        hs2w_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_lvl[i]),
            .sync_o (sync_lvl[i])
        );
    end

    assign a_low = !sync_lvl[0];
    assign b_low = !sync_lvl[1];

    hs2w_bitphase u_bit (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_i     (bit_go),
        .val_i    (bit_val),
        .a_low_i  (a_low),
        .b_low_i  (b_low),
        .pull_a_o (pull_a),
        .pull_b_o (pull_b),
        .idle_o   (eng_idle),
        .done_o   (eng_done)
    );

    hs2w_framer #(.DATA_W(DATA_W)) u_frm (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_data    (in_data),
        .in_valid   (in_valid),
        .in_last    (in_last),
        .in_reply   (in_reply),
        .in_ready   (in_ready),
        .eng_idle_i (eng_idle),
        .eng_done_i (eng_done),
        .b_low_i    (b_low),
        .go_o       (bit_go),
        .val_o      (bit_val),
        .released_o (released_o)
    );

    assign pd_a_n = !pull_a;
    assign pd_b_n = !pull_b;

    // R11: never both wires pulled together
    a_r11_one_wire: assert property (@(posedge clk) disable iff (!rst_n)
        pd_a_n || pd_b_n);

    // R9: hand-over is reported with both wires let go
    a_r9_quiet_release: assert property (@(posedge clk) disable iff (!rst_n)
        released_o |-> (pd_a_n && pd_b_n));

    // R7: no byte window while a wire is held
    a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (!pd_a_n || !pd_b_n) |-> !in_ready);

endmodule

// File: tb/tb_hs2w_tx.sv
`timescale 1ns/1ps
module tb_hs2w_tx;
    localparam int DATA_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [DATA_W-1:0] in_data;
    logic in_valid, in_last, in_reply;
    logic in_ready;
    logic pd_a_n, pd_b_n, released_o;
    logic fe_a = 1'b0, fe_b = 1'b0;
    logic line_a, line_b;

    assign line_a = ~((~pd_a_n) | fe_a);
    assign line_b = ~((~pd_b_n) | fe_b);

    hs2w_tx #(.DATA_W(DATA_W), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n),
        .in_data(in_data), .in_valid(in_valid), .in_last(in_last),
        .in_reply(in_reply), .in_ready(in_ready),
        .line_a_i(line_a), .line_b_i(line_b),
        .pd_a_n(pd_a_n), .pd_b_n(pd_b_n), .released_o(released_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int rel_cnt = 0;
    bit finished = 1'b0;
    int unsigned seed = 32'h1234_5678;

    int exp_bit[$];
    int exp_kind[$];   // 0 preamble, 1 start, 2 data, 3 end
    int exp_turn[$];
    logic [DATA_W-1:0] msg_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int rdly();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 16) & 32'd7);
    endfunction

    // per-cycle monitor: R11, R7, R9
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (!pd_a_n || !pd_b_n) begin
                    chk(pd_a_n || pd_b_n, "R11", "both wires pulled", 1, 0);
                    chk(!in_ready, "R7", "ready while wire pulled", longint'(in_ready), 0);
                end
                if (released_o) begin
                    rel_cnt++;
                    chk(pd_a_n && pd_b_n, "R9", "wire pulled at release pulse",
                        longint'({pd_a_n, pd_b_n}), 3);
                end
            end
        end
    end

    // far-end model
    int fe_st = 0;
    int fe_cnt = 0;
    int fe_bit = 0;
    int ack_cyc = 0;
    initial begin
        forever begin
            @(negedge clk);
            case (fe_st)
                0: begin
                    if (!pd_a_n) begin
                        fe_bit = 0; fe_cnt = rdly(); fe_st = 1;
                    end else if (!pd_b_n) begin
                        fe_bit = 1; fe_cnt = rdly(); fe_st = 1;
                    end
                end
                1: begin
                    chk(fe_bit ? !pd_b_n : !pd_a_n, fe_bit ? "R3" : "R2",
                        "wire let go before acknowledge", 1, 0);
                    if (fe_cnt == 0) begin
                        if (fe_bit == 0) fe_b = 1'b1; else fe_a = 1'b1;
                        ack_cyc = cyc;
                        fe_st = 2;
                    end else fe_cnt--;
                end
                2: begin
                    if ((fe_bit == 0 && pd_a_n) || (fe_bit == 1 && pd_b_n)) begin
                        chk(cyc - ack_cyc >= 3, "R8", "edges from acknowledge to release",
                            cyc - ack_cyc, 3);
                        if (exp_bit.size() == 0) begin
                            chk(1'b0, "R6", "bit after message end", fe_bit, -1);
                            fe_st = 3;
                        end else begin
                            automatic int eb = exp_bit.pop_front();
                            automatic int ek = exp_kind.pop_front();
                            automatic int et = exp_turn.pop_front();
                            case (ek)
                                0: chk(fe_bit == eb, "R5", "preamble bit", fe_bit, eb);
                                1: chk(fe_bit == eb, "R4", "start bit", fe_bit, eb);
                                2: chk(fe_bit == eb, "R4", "data bit lsb first", fe_bit, eb);
                                default: chk(fe_bit == eb, "R6", "end bit", fe_bit, eb);
                            endcase
                            fe_st = et ? 4 : 3;
                        end
                        fe_cnt = rdly();
                    end
                end
                3: begin
                    chk(pd_a_n && pd_b_n, fe_bit ? "R3" : "R2",
                        "next bit before acknowledge withdrawn", longint'({pd_a_n, pd_b_n}), 3);
                    if (fe_cnt == 0) begin
                        fe_a = 1'b0; fe_b = 1'b0; fe_st = 0;
                    end else fe_cnt--;
                end
                4: begin
                    chk(pd_a_n && pd_b_n, "R9", "wire pulled before turnaround",
                        longint'({pd_a_n, pd_b_n}), 3);
                    if (fe_cnt == 0) begin
                        fe_a = 1'b0; fe_b = 1'b1;
                        fe_cnt = 8 + rdly();
                        fe_st = 5;
                    end else fe_cnt--;
                end
                5: begin
                    chk(pd_a_n && pd_b_n, "R9", "wire pulled after hand-over",
                        longint'({pd_a_n, pd_b_n}), 3);
                    if (fe_cnt == 0) begin
                        fe_b = 1'b0; fe_st = 0;
                    end else fe_cnt--;
                end
                default: fe_st = 0;
            endcase
        end
    end

    task automatic run_msg(input bit rep_first, input bit rep_last, input int gap);
        automatic int n = msg_q.size();
        for (int i = 0; i < n; i++) begin
            if (i == 0) begin
                exp_bit.push_back(1); exp_kind.push_back(0); exp_turn.push_back(0);
            end
            exp_bit.push_back(0); exp_kind.push_back(1); exp_turn.push_back(0);
            for (int k = 0; k < DATA_W; k++) begin
                exp_bit.push_back(int'(msg_q[i][k])); exp_kind.push_back(2); exp_turn.push_back(0);
            end
        end
        exp_bit.push_back(1); exp_kind.push_back(3); exp_turn.push_back(int'(rep_last));
        for (int i = 0; i < n; i++) begin
            repeat (gap) @(negedge clk);
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = msg_q[i];
            in_last  = (i == n - 1);
            in_reply = (i == n - 1) ? rep_last : ((i == 0) ? rep_first : 1'b0);
            while (!in_ready) @(negedge clk);
            @(negedge clk);
            in_valid = 1'b0;
            in_reply = 1'b0;
            in_last  = 1'b0;
        end
    endtask

    task automatic finish_msg(input int rel_before, input int rel_exp, input string rtag);
        automatic int t = 0;
        @(negedge clk);
        while ((exp_bit.size() != 0 || fe_st != 0) && t < 20000) begin
            @(negedge clk);
            t++;
        end
        chk(exp_bit.size() == 0, "R6", "bits left unsent", exp_bit.size(), 0);
        repeat (4) @(negedge clk);
        chk(rel_cnt - rel_before == rel_exp, rtag, "release pulses", rel_cnt - rel_before, rel_exp);
        chk(in_ready == 1'b1, "R7", "ready after message", longint'(in_ready), 1);
        chk(pd_a_n && pd_b_n, "R9", "wires idle after message", longint'({pd_a_n, pd_b_n}), 3);
    endtask

    initial begin
        automatic int r0;
        in_valid = 1'b0; in_data = '0; in_last = 1'b0; in_reply = 1'b0;
        repeat (4) @(negedge clk);
        chk(pd_a_n && pd_b_n, "R1", "enables in reset", longint'({pd_a_n, pd_b_n}), 3);
        chk(in_ready == 1'b1, "R1", "ready in reset", longint'(in_ready), 1);
        chk(released_o == 1'b0, "R1", "release in reset", longint'(released_o), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(pd_a_n && pd_b_n && in_ready && !released_o, "R1", "state after reset",
            longint'({pd_a_n, pd_b_n, in_ready, released_o}), 14);

        // single byte, no reply
        msg_q = '{8'hA5};
        r0 = rel_cnt; run_msg(1'b0, 1'b0, 0); finish_msg(r0, 0, "R10");

        // three bytes with pauses, all-zero and all-one values
        msg_q = '{8'h00, 8'hFF, 8'h3C};
        r0 = rel_cnt; run_msg(1'b0, 1'b0, 7); finish_msg(r0, 0, "R10");

        // reply requested on the closing byte
        msg_q = '{8'h81};
        r0 = rel_cnt; run_msg(1'b0, 1'b1, 0); finish_msg(r0, 1, "R9");

        // reply flag on a non-final byte is ignored
        msg_q = '{8'h5A, 8'hC3};
        r0 = rel_cnt; run_msg(1'b1, 1'b0, 2); finish_msg(r0, 0, "R10");

        // turnaround, then a fresh message afterwards
        msg_q = '{8'h7E, 8'h01};
        r0 = rel_cnt; run_msg(1'b0, 1'b1, 0); finish_msg(r0, 1, "R9");
        msg_q = '{8'h12};
        r0 = rel_cnt; run_msg(1'b0, 1'b0, 1); finish_msg(r0, 0, "R10");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule